// File: doc/BRIEF.md
# Nibble-to-Word Transmit Input Demultiplexer

This block sits at the digital input of a narrow parallel transmit port. The port carries half-words, called nibbles, on a small bus. A strobe marks which nibble opens a word. The block joins each pair of nibbles into one 12-bit two's-complement sample and hands that sample to a downstream interpolation stage. It marks each sample with a one-cycle valid pulse.

Static configuration inputs set five things:
- the clock edge on which the port is sampled;
- which of the two nibbles forms the upper half of the word;
- whether nibbles are six or five bits wide;
- a bypass in which one full word is taken on every clock;
- an optional conversion of the output to offset binary.

In multiplexed mode the port clock runs at twice the word rate. In bypass it runs at the word rate. The configuration inputs are assumed to change only while the port is idle.

Top module: `txp_nibble_demux`

## Requirements
- R1: In the default 6+6 mode, a nibble `tx_data[5:0]` sampled with `tx_sync` high is the first nibble, and the next nibble sampled with `tx_sync` low is the second. The word is `{first, second}`. The word appears on `word_data`, with `word_vld` high, one clock after the clock edge at which the second nibble's capture register loads.
- R2: With `cfg_fall_edge` = 0, data and sync are captured on the rising clock edge. With `cfg_fall_edge` = 1, they are captured on the falling edge before that rising edge. Both settings give the same latency.
- R3: With `cfg_swap` = 1, the nibble sampled first becomes the low half of the word and the second becomes the high half.
- R4: With `cfg_five` = 1, only `tx_data[4:0]` is used. The output is `{hi5, lo5, 2'b00}`, so `word_data[1:0]` is always zero.
- R5: A nibble sampled with sync high while a first nibble is pending restarts pairing, and the pending nibble is dropped. A nibble sampled with sync low while no first nibble is pending is dropped.
- R6: With `cfg_bypass` = 1, `tx_data[11:0]` is taken as a whole word on every clock, `word_vld` is high every cycle, and `tx_sync` has no effect.
- R7: With `cfg_offset` = 1, only bit 11 of the word is inverted. This maps 0x7FF (maximum) to 0xFFF and 0x800 (minimum) to 0x000.
- R8: In multiplexed mode `word_vld` is never high on two consecutive cycles. `word_data` holds its value between valid pulses.
- R9: The synchronous active-low reset `rst_n` clears `word_vld` and any pending first nibble, but leaves `word_data` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_fall_edge | input | 1 | 1 = capture on the falling edge |
| cfg_swap | input | 1 | 1 = first nibble is the low half |
| cfg_five | input | 1 | 1 = 5+5 nibble split |
| cfg_bypass | input | 1 | 1 = one full word per clock |
| cfg_offset | input | 1 | 1 = offset binary output |
| tx_sync | input | 1 | High marks the first nibble of a word |
| tx_data | input | 12 | Nibble on the low bits, or a full word in bypass |
| word_vld | output | 1 | One-cycle pulse per assembled word |
| word_data | output | 12 | Assembled sample, held between pulses |

## Verification
The 6+6 path is driven with complementary halves, all-ones halves and the extreme codes, so that a crossed or misplaced half shows in the output. The same two nibbles are then repeated with swap set, with the 5+5 split (high bits set on the bus, to show they are ignored) and with offset conversion, so that each word differs only by the option under test.

For the capture edge test, the bus is changed between the falling and the rising edge, so each edge setting yields a different word. The sync tests cover:
- a doubled first nibble;
- an orphan second nibble;
- a reset between the two halves.

Bypass is tried with sync toggling, to show that sync has no effect there.

// File: rtl/txp_pkg.sv
// Shared types for the transmit-port nibble demultiplexer.
package txp_pkg;
    typedef enum logic {
        PAIR_IDLE = 1'b0,
        PAIR_HAVE = 1'b1
    } pair_state_e;
endpackage

// File: rtl/txp_capture.sv
// Input capture stage.
// Samples sync and data on the rising edge, or on the falling edge and then
// retimes to the rising edge, as cfg_fall_edge selects. Either way the
// captured beat is presented after the same rising edge.
// Assumes cfg_fall_edge is static while traffic flows.
module txp_capture #(
    parameter int WORD_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_fall_edge,
    input  logic              tx_sync,
    input  logic [WORD_W-1:0] tx_data,
    output logic              cap_sync,
    output logic [WORD_W-1:0] cap_data
);

    logic              neg_sync;
    logic [WORD_W-1:0] neg_data;

    // Falling-edge copy of the port pins.
    always_ff @(negedge clk) begin
        neg_data <= tx_data;
        if (!rst_n) neg_sync <= 1'b0;
        else        neg_sync <= tx_sync;
    end

    // Rising-edge capture: choose the pins directly or the falling-edge copy.
    always_ff @(posedge clk) begin
        cap_data <= cfg_fall_edge ? neg_data : tx_data;
        if (!rst_n) cap_sync <= 1'b0;
        else        cap_sync <= cfg_fall_edge ? neg_sync : tx_sync;
    end

    // R2: with rising capture, the captured data equals the pins one edge earlier.
    p_rise_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!cfg_fall_edge) |-> (cap_data == $past(tx_data)));

endmodule

// File: rtl/txp_pairer.sv
// Nibble pairing engine.
// Holds the first nibble of a word, which is flagged by sync. It forms the
// word when the next nibble arrives without sync. It orders the halves by
// cfg_swap and packs 6+6 or 5+5 (left-justified, zero pad). In bypass,
// every captured beat is a whole word. pair_fire and pair_word are
// combinational from the capture register and the pending state.
// Assumes WORD_W == 2*NIB_WIDE and that the configuration is static during
// traffic.
module txp_pairer
    import txp_pkg::*;
#(
    parameter int WORD_W     = 12,
    parameter int NIB_WIDE   = 6,
    parameter int NIB_NARROW = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_swap,
    input  logic              cfg_five,
    input  logic              cfg_bypass,
    input  logic              cap_sync,
    input  logic [WORD_W-1:0] cap_data,
    output logic              pair_fire,
    output logic [WORD_W-1:0] pair_word
);

    localparam int PAD_W = WORD_W - 2*NIB_NARROW;

    pair_state_e         state_q;
    logic [NIB_WIDE-1:0] first_q;
    logic [NIB_WIDE-1:0] second_nib;
    logic [NIB_WIDE-1:0] hi_nib;
    logic [NIB_WIDE-1:0] lo_nib;

    assign second_nib = cap_data[NIB_WIDE-1:0];

    // Pairing state: a sync beat opens a word; any other beat closes or is dropped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PAIR_IDLE;
        end else if (cfg_bypass) begin
            state_q <= PAIR_IDLE;
        end else if (cap_sync) begin
            state_q <= PAIR_HAVE;
        end else begin
            state_q <= PAIR_IDLE;
        end
    end

    // First-nibble holding register, loaded on every sync beat.
    always_ff @(posedge clk) begin
        if (cap_sync) first_q <= second_nib;
    end

    // Half ordering.
    always_comb begin
        hi_nib = cfg_swap ? second_nib : first_q;
        lo_nib = cfg_swap ? first_q    : second_nib;
    end

    // Word packing and fire decision.
    always_comb begin
        if (cfg_bypass) begin
            pair_fire = 1'b1;
            pair_word = cap_data;
        end else begin
            pair_fire = (state_q == PAIR_HAVE) && !cap_sync;
            if (cfg_five)
                pair_word = {hi_nib[NIB_NARROW-1:0], lo_nib[NIB_NARROW-1:0], {PAD_W{1'b0}}};
            else
                pair_word = {hi_nib, lo_nib};
        end
    end

    // R5: a multiplexed word forms only from a sync beat followed by a non-sync beat.
    p_pair_needs_opener_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pair_fire && !cfg_bypass) |-> ($past(cap_sync) && !cap_sync));

    // R6: in bypass, every cycle yields a word.
    p_bypass_every_beat_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_bypass |-> pair_fire);

endmodule

// File: rtl/txp_format.sv
// Output formatting and register stage.
// Optionally converts the word to offset binary by inverting the top bit,
// then registers the word and its valid pulse. The word register has no
// reset, so reset leaves the last word in place.
module txp_format #(
    parameter int WORD_W     = 12,
    parameter int NIB_NARROW = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_offset,
    input  logic              cfg_five,
    input  logic              cfg_bypass,
    input  logic              pair_fire,
    input  logic [WORD_W-1:0] pair_word,
    output logic              word_vld,
    output logic [WORD_W-1:0] word_data
);

    localparam int          PAD_W    = WORD_W - 2*NIB_NARROW;
    localparam logic [WORD_W-1:0] MSB_MASK = {1'b1, {(WORD_W-1){1'b0}}};

    logic seen_q;

    // Valid pulse register, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) word_vld <= 1'b0;
        else        word_vld <= pair_fire;
    end

    // Word register with the optional sign-bit inversion; loads only on fire.
    always_ff @(posedge clk) begin
        if (rst_n && pair_fire)
            word_data <= cfg_offset ? (pair_word ^ MSB_MASK) : pair_word;
    end

    // Checker state: a word has been produced since time zero.
    always_ff @(posedge clk) begin
        if (word_vld) seen_q <= 1'b1;
        else if ($isunknown(seen_q)) seen_q <= 1'b0;
    end

    // R8: in multiplexed mode no two valid pulses are back to back.
    p_single_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (word_vld && !cfg_bypass) |=> (!word_vld || cfg_bypass));

    // R8: the word does not move between pulses once one has been seen.
    p_hold_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && !word_vld) |-> $stable(word_data));

    // R4: a 5+5 word has zero pad bits at the bottom.
    p_pad_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (word_vld && $past(cfg_five) && $past(!cfg_bypass)) |-> (word_data[PAD_W-1:0] == '0));

    // R9: reset drops the valid output on the following cycle.
    p_reset_clear_r9: assert property (@(posedge clk)
        !rst_n |=> !word_vld);

endmodule

// File: rtl/txp_nibble_demux.sv
// Transmit-port nibble demultiplexer, top level.
// Pipeline: capture (edge select) -> pairer (sync pairing and packing) ->
// format (offset option and output register). A nibble present at the pins
// for capture edge k appears as a word after rising edge k+1.
// Assumes the configuration changes only while the port is idle.
module txp_nibble_demux #(
    parameter int WORD_W     = 12,
    parameter int NIB_WIDE   = 6,
    parameter int NIB_NARROW = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_fall_edge,
    input  logic              cfg_swap,
    input  logic              cfg_five,
    input  logic              cfg_bypass,
    input  logic              cfg_offset,
    input  logic              tx_sync,
    input  logic [WORD_W-1:0] tx_data,
    output logic              word_vld,
    output logic [WORD_W-1:0] word_data
);

    logic              cap_sync;
    logic [WORD_W-1:0] cap_data;
    logic              pair_fire;
    logic [WORD_W-1:0] pair_word;

    txp_capture #(.WORD_W(WORD_W)) u_capture (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_fall_edge (cfg_fall_edge),
        .tx_sync       (tx_sync),
        .tx_data       (tx_data),
        .cap_sync      (cap_sync),
        .cap_data      (cap_data)
    );

    txp_pairer #(
        .WORD_W     (WORD_W),
        .NIB_WIDE   (NIB_WIDE),
        .NIB_NARROW (NIB_NARROW)
    ) u_pairer (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_swap   (cfg_swap),
        .cfg_five   (cfg_five),
        .cfg_bypass (cfg_bypass),
        .cap_sync   (cap_sync),
        .cap_data   (cap_data),
        .pair_fire  (pair_fire),
        .pair_word  (pair_word)
    );

    txp_format #(
        .WORD_W     (WORD_W),
        .NIB_NARROW (NIB_NARROW)
    ) u_format (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_offset (cfg_offset),
        .cfg_five   (cfg_five),
        .cfg_bypass (cfg_bypass),
        .pair_fire  (pair_fire),
        .pair_word  (pair_word),
        .word_vld   (word_vld),
        .word_data  (word_data)
    );

endmodule

// File: tb/txp_nibble_demux_tb.sv
module txp_nibble_demux_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_fall_edge = 1'b0, cfg_swap = 1'b0, cfg_five = 1'b0;
    logic        cfg_bypass = 1'b0, cfg_offset = 1'b0;
    logic        tx_sync = 1'b0;
    logic [11:0] tx_data = '0;
    logic        word_vld;
    logic [11:0] word_data;

    int          checks = 0;
    int          errors = 0;
    bit          mon_en = 1'b0;
    bit          done = 1'b0;
    logic [11:0] exp_q[$];
    string       req_q[$];

    always #4 clk = ~clk;

    txp_nibble_demux u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_fall_edge(cfg_fall_edge),
        .cfg_swap(cfg_swap), .cfg_five(cfg_five), .cfg_bypass(cfg_bypass),
        .cfg_offset(cfg_offset), .tx_sync(tx_sync), .tx_data(tx_data),
        .word_vld(word_vld), .word_data(word_data)
    );

    task automatic check(input bit ok, input string req, input logic [11:0] act, input logic [11:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one beat just after a rising edge.
    task automatic drive(input logic s, input logic [11:0] d);
        @(posedge clk);
        #1;
        tx_sync = s;
        tx_data = d;
    endtask

    // Drive value a before the falling edge and b after it.
    task automatic drive2(input logic s, input logic [11:0] a, input logic [11:0] b);
        @(posedge clk);
        #1;
        tx_sync = s;
        tx_data = a;
        #5;
        tx_data = b;
    endtask

    task automatic expect_word(input logic [11:0] w, input string req);
        exp_q.push_back(w);
        req_q.push_back(req);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive(1'b0, 12'h000);
    endtask

    // Monitor: pop and compare on every valid pulse.
    always @(negedge clk) begin
        if (mon_en && rst_n && word_vld) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R5/R8 unexpected word", word_data, 12'h000);
            end else begin
                logic [11:0] e;
                string r;
                e = exp_q.pop_front();
                r = req_q.pop_front();
                check(word_data === e, r, word_data, e);
            end
        end
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%h expected=%h", 12'h0, 12'h1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [11:0] held;
        repeat (3) @(posedge clk);
        #2;
        check(word_vld === 1'b0, "R9 reset valid", {11'b0, word_vld}, 12'h000);
        @(posedge clk);
        #1;
        rst_n = 1'b1;
        mon_en = 1'b1;
        idle(2);

        // R1: default 6+6 with several patterns.
        drive(1, 12'h02A); drive(0, 12'h015); expect_word(12'hA95, "R1 pattern a");
        drive(1, 12'h03F); drive(0, 12'h000); expect_word(12'hFC0, "R1 pattern b");
        drive(1, 12'h000); drive(0, 12'h03F); expect_word(12'h03F, "R1 pattern c");
        drive(1, 12'h01F); drive(0, 12'h03F); expect_word(12'h7FF, "R1 max");
        drive(1, 12'h020); drive(0, 12'h000); expect_word(12'h800, "R1 min");
        idle(3);

        // R8: word held, valid low between pulses.
        @(negedge clk);
        check(word_vld === 1'b0, "R8 valid low idle", {11'b0, word_vld}, 12'h000);
        check(word_data === 12'h800, "R8 word held", word_data, 12'h800);

        // R9: reset between halves drops the pending nibble and keeps the word.
        drive(1, 12'h011);
        @(posedge clk); #1; rst_n = 1'b0; tx_sync = 1'b0; tx_data = 12'h022;
        @(posedge clk); #1; rst_n = 1'b1; tx_sync = 1'b0; tx_data = 12'h033;
        idle(3);
        @(negedge clk);
        check(word_data === 12'h800, "R9 word kept over reset", word_data, 12'h800);
        check(exp_q.size() == 0, "R9 no word after reset", 12'h0, 12'h0);

        // R5: doubled opener restarts; orphan second nibble dropped.
        drive(1, 12'h011); drive(1, 12'h022); drive(0, 12'h033); expect_word(12'h8B3, "R5 restart");
        drive(0, 12'h005); drive(1, 12'h001); drive(0, 12'h002); expect_word(12'h042, "R5 orphan");
        idle(3);

        // R3: swapped order.
        cfg_swap = 1'b1;
        drive(1, 12'h02A); drive(0, 12'h015); expect_word(12'h56A, "R3 swap");
        idle(3);
        cfg_swap = 1'b0;

        // R4: 5+5 split, bit 5 ignored.
        cfg_five = 1'b1;
        drive(1, 12'h01F); drive(0, 12'h00A); expect_word(12'hFA8, "R4 five a");
        drive(1, 12'h03F); drive(0, 12'h021); expect_word(12'hF84, "R4 five upper bit ignored");
        idle(3);
        cfg_five = 1'b0;

        // R7: offset binary.
        cfg_offset = 1'b1;
        drive(1, 12'h01F); drive(0, 12'h03F); expect_word(12'hFFF, "R7 max to offset");
        drive(1, 12'h020); drive(0, 12'h000); expect_word(12'h000, "R7 min to offset");
        drive(1, 12'h02A); drive(0, 12'h015); expect_word(12'h295, "R7 only msb flips");
        idle(3);
        cfg_offset = 1'b0;

        // R2: data changes after the falling edge; each edge sees a different nibble.
        drive2(1, 12'h00A, 12'h015); drive2(0, 12'h002, 12'h02B); expect_word(12'h56B, "R2 rising edge");
        idle(3);
        cfg_fall_edge = 1'b1;
        idle(2);
        drive2(1, 12'h00A, 12'h015); drive2(0, 12'h002, 12'h02B); expect_word(12'h282, "R2 falling edge");
        idle(3);
        cfg_fall_edge = 1'b0;
        idle(2);

        // R6: bypass, sync ignored, valid every cycle.
        mon_en = 1'b0;
        cfg_bypass = 1'b1;
        drive(1, 12'h123);
        @(posedge clk); @(posedge clk); #2;
        check(word_vld === 1'b1 && word_data === 12'h123, "R6 bypass word a", word_data, 12'h123);
        drive(0, 12'hABC);
        @(posedge clk); @(posedge clk); #2;
        check(word_vld === 1'b1 && word_data === 12'hABC, "R6 bypass word b sync low", word_data, 12'hABC);
        @(posedge clk); #2;
        check(word_vld === 1'b1, "R6 valid every cycle", {11'b0, word_vld}, 12'h001);
        held = word_data;
        cfg_bypass = 1'b0;
        idle(4);
        mon_en = 1'b1;
        drive(1, 12'h001); drive(0, 12'h001); expect_word(12'h041, "R1 after bypass");
        idle(4);

        check(exp_q.size() == 0, "R8 all words seen", 12'(exp_q.size()), 12'h000);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule